// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block connects two 8-bit buses, called A and B, through two independent storage paths. The forward path carries data from A to B. The return path carries data from B to A. Each path has three active-low controls: a path select, a capture gate and a drive gate.

While a path is selected and its capture gate is low, its storage register is transparent and loads the source bus on every clock. When the capture gate returns high, the register keeps the value it loaded at the last edge before that. Deselecting the path freezes the register whatever the capture gate does.

The destination bus is driven only while the path is selected and its drive gate is low. Because a bus may not be tristated inside the device, each bus appears as three ports: an input vector, an output vector and a drive flag. All outputs are registered. Each output reflects the inputs sampled at the previous rising edge of `clk`.

Top module: `bus_xcvr_latched`

## Requirements
- R1: While `rst` is high at a rising edge, both stored values are cleared to zero. After that edge, `a_oe`, `b_oe` and `contention` are 0, and `a_out` and `b_out` are zero.
- R2: When `fw_sel_n`=0 and `fw_cap_n`=0 at an edge, the forward register loads `a_in`. If `fw_drv_n` is also 0, `b_out` equals that `a_in` after the edge.
- R3: When `fw_cap_n` is 1 at an edge, the forward register keeps its value, and changes on `a_in` have no effect on `b_out`.
- R4: When `fw_sel_n` is 1 at an edge, the forward register keeps its value whatever `fw_cap_n` and `a_in` are. This is observed on `b_out` once the path is driven again with `fw_cap_n`=1.
- R5: After an edge, `b_oe` is 1 exactly when `fw_sel_n`=0 and `fw_drv_n`=0 were sampled at that edge. Otherwise `b_oe` is 0.
- R6: While `b_oe` is 1, `b_out` equals the forward register's value, not inverted. While `b_oe` is 0, `b_out` is all zeros. The same holds for `a_out` and `a_oe` on the return path.
- R7: The return path (`rv_sel_n`, `rv_cap_n`, `rv_drv_n`, from `b_in` to `a_out` and `a_oe`) follows R2 to R5 and is independent of the forward controls.
- R8: After an edge, `contention` is 1 exactly when both paths were set to drive at that edge. That means `fw_sel_n`, `fw_drv_n`, `rv_sel_n` and `rv_drv_n` were all 0.
- R9: A capture gate held low for a single clock cycle loads the source bus value of that cycle. The value is then held after the gate returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Bus A value seen by the block |
| a_out | output | 8 | Value driven onto bus A by the return path |
| a_oe | output | 1 | 1 while the block drives bus A |
| b_in | input | 8 | Bus B value seen by the block |
| b_out | output | 8 | Value driven onto bus B by the forward path |
| b_oe | output | 1 | 1 while the block drives bus B |
| fw_sel_n | input | 1 | Forward path select, active low |
| fw_cap_n | input | 1 | Forward capture gate, active low (transparent when low) |
| fw_drv_n | input | 1 | Forward drive gate, active low |
| rv_sel_n | input | 1 | Return path select, active low |
| rv_cap_n | input | 1 | Return capture gate, active low |
| rv_drv_n | input | 1 | Return drive gate, active low |
| contention | output | 1 | 1 when both buses were driven at once |

## Verification
The two paths can both drive their destination bus in the same cycle. This raises `contention`, and each path must still carry its own value without disturbing the other. The directed sequence first turns both paths on together with different data and then drops one drive gate. The random phase sets both select and drive gates low with high probability, so overlaps are frequent. In every cycle, the bench compares each bus output, each drive flag and the contention flag against two independent per-path models kept in bench functions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_FW  = 0;
  localparam int unsigned DIR_RV  = 1;

  typedef struct packed {
    logic sel_n;
    logic cap_n;
    logic drv_n;
  } path_ctrl_t;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  path_ctrl_t   ctrl,
  input  logic [W-1:0] din,
  output logic [W-1:0] store_next,
  output logic [W-1:0] store_q
);

  logic load;

  always_comb begin
    load       = !ctrl.sel_n && !ctrl.cap_n;
    store_next = load ? din : store_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else begin
      store_q <= store_next;
    end
  end

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  path_ctrl_t   ctrl,
  input  logic [W-1:0] value,
  output logic         drive_next,
  output logic [W-1:0] bus_q,
  output logic         oe_q
);

  always_comb begin
    drive_next = !ctrl.sel_n && !ctrl.drv_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      bus_q <= drive_next ? value : '0;
      oe_q  <= drive_next;
    end
  end

endmodule

// File: rtl/xcvr_conflict.sv
module xcvr_conflict
  import xcvr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DIR-1:0] drive_next,
  output logic               flag_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= &drive_next;
    end
  end

endmodule

// File: rtl/bus_xcvr_latched.sv
module bus_xcvr_latched
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             fw_sel_n,
  input  logic             fw_cap_n,
  input  logic             fw_drv_n,
  input  logic             rv_sel_n,
  input  logic             rv_cap_n,
  input  logic             rv_drv_n,
  output logic             contention
);

  path_ctrl_t         ctrl_arr [NUM_DIR];
  logic [WIDTH-1:0]   src_arr  [NUM_DIR];
  logic [WIDTH-1:0]   nxt_arr  [NUM_DIR];
  logic [WIDTH-1:0]   held_arr [NUM_DIR];
  logic [WIDTH-1:0]   out_arr  [NUM_DIR];
  logic [NUM_DIR-1:0] oe_vec;
  logic [NUM_DIR-1:0] drv_next_vec;

  always_comb begin
    ctrl_arr[DIR_FW] = '{sel_n: fw_sel_n, cap_n: fw_cap_n, drv_n: fw_drv_n};
    ctrl_arr[DIR_RV] = '{sel_n: rv_sel_n, cap_n: rv_cap_n, drv_n: rv_drv_n};
    src_arr[DIR_FW]  = a_in;
    src_arr[DIR_RV]  = b_in;
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_path
    xcvr_store #(.W(WIDTH)) u_store (
      .clk        (clk),
      .rst        (rst),
      .ctrl       (ctrl_arr[d]),
      .din        (src_arr[d]),
      .store_next (nxt_arr[d]),
      .store_q    (held_arr[d])
    );

    xcvr_drive #(.W(WIDTH)) u_drive (
      .clk        (clk),
      .rst        (rst),
      .ctrl       (ctrl_arr[d]),
      .value      (nxt_arr[d]),
      .drive_next (drv_next_vec[d]),
      .bus_q      (out_arr[d]),
      .oe_q       (oe_vec[d])
    );
  end

  xcvr_conflict u_conflict (
    .clk        (clk),
    .rst        (rst),
    .drive_next (drv_next_vec),
    .flag_q     (contention)
  );

  always_comb begin
    b_out = out_arr[DIR_FW];
    b_oe  = oe_vec[DIR_FW];
    a_out = out_arr[DIR_RV];
    a_oe  = oe_vec[DIR_RV];
  end

endmodule

// File: rtl/bus_xcvr_latched_chk.sv
module bus_xcvr_latched_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic             fw_sel_n,
  input logic             fw_cap_n,
  input logic             fw_drv_n,
  input logic             rv_sel_n,
  input logic             rv_cap_n,
  input logic             rv_drv_n,
  input logic             contention
);

  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  AST_RESET_QUIET: assert property (@(posedge clk)
    (seen_edge && $past(rst)) |-> (!a_oe && !b_oe && !contention && a_out == '0 && b_out == '0)); // R1

  AST_FW_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $past(!rst && !fw_sel_n && !fw_cap_n && !fw_drv_n)) |-> (b_oe && b_out == $past(a_in))); // R2

  AST_FW_HELD: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $past(!rst && fw_cap_n) && $past(b_oe) && b_oe) |-> $stable(b_out)); // R3

  AST_FW_DRIVE_GATE: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $past(!rst)) |-> (b_oe == $past(!fw_sel_n && !fw_drv_n))); // R5

  AST_IDLE_ZERO_B: assert property (@(posedge clk) disable iff (rst)
    !b_oe |-> (b_out == '0)); // R6

  AST_IDLE_ZERO_A: assert property (@(posedge clk) disable iff (rst)
    !a_oe |-> (a_out == '0)); // R6

  AST_RV_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $past(!rst && !rv_sel_n && !rv_cap_n && !rv_drv_n)) |-> (a_oe && a_out == $past(b_in))); // R7

  AST_BOTH_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (seen_edge && $past(!rst)) |-> (contention == $past(!fw_sel_n && !fw_drv_n && !rv_sel_n && !rv_drv_n))); // R8

endmodule

bind bus_xcvr_latched bus_xcvr_latched_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe),
  .fw_sel_n   (fw_sel_n),
  .fw_cap_n   (fw_cap_n),
  .fw_drv_n   (fw_drv_n),
  .rv_sel_n   (rv_sel_n),
  .rv_cap_n   (rv_cap_n),
  .rv_drv_n   (rv_drv_n),
  .contention (contention)
);

// File: tb/bus_xcvr_latched_tb.sv
`timescale 1ns/1ps
module bus_xcvr_latched_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe, contention;
  logic       fw_sel_n = 1'b1, fw_cap_n = 1'b1, fw_drv_n = 1'b1;
  logic       rv_sel_n = 1'b1, rv_cap_n = 1'b1, rv_drv_n = 1'b1;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  logic [7:0] m_fw = '0, m_rv = '0;
  logic [7:0] e_b_out = '0, e_a_out = '0;
  logic       e_b_oe = 1'b0, e_a_oe = 1'b0, e_cont = 1'b0;

  always #2.5 clk = ~clk;

  bus_xcvr_latched u_dut (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .fw_sel_n(fw_sel_n), .fw_cap_n(fw_cap_n), .fw_drv_n(fw_drv_n),
    .rv_sel_n(rv_sel_n), .rv_cap_n(rv_cap_n), .rv_drv_n(rv_drv_n),
    .contention(contention)
  );

  function automatic logic [7:0] next_hold(logic [7:0] cur, logic sel_n, logic cap_n, logic [7:0] src);
    return (!sel_n && !cap_n) ? src : cur;
  endfunction

  function automatic logic drives(logic sel_n, logic drv_n);
    return !sel_n && !drv_n;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Advance one edge with the current inputs, update the model, compare all outputs.
  task automatic tick();
    if (rst) begin
      m_fw = '0; m_rv = '0;
      e_b_oe = 0; e_a_oe = 0; e_cont = 0; e_b_out = '0; e_a_out = '0;
    end else begin
      m_fw    = next_hold(m_fw, fw_sel_n, fw_cap_n, a_in);
      m_rv    = next_hold(m_rv, rv_sel_n, rv_cap_n, b_in);
      e_b_oe  = drives(fw_sel_n, fw_drv_n);
      e_a_oe  = drives(rv_sel_n, rv_drv_n);
      e_cont  = e_b_oe && e_a_oe;
      e_b_out = e_b_oe ? m_fw : '0;
      e_a_out = e_a_oe ? m_rv : '0;
    end
    @(posedge clk);
    #1;
    check("R6", "b_out", b_out, e_b_out);
    check("R5", "b_oe", b_oe, e_b_oe);
    check("R7", "a_out", a_out, e_a_out);
    check("R7", "a_oe", a_oe, e_a_oe);
    check("R8", "contention", contention, e_cont);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    @(negedge clk);
    // R1: reset clears everything
    a_in = 8'hAA; b_in = 8'h55;
    fw_sel_n = 0; fw_cap_n = 0; fw_drv_n = 0;
    tick();
    check("R1", "b_oe after reset", b_oe, 0);
    check("R1", "b_out after reset", b_out, 0);
    check("R1", "contention after reset", contention, 0);
    rst = 0;
    fw_sel_n = 1; fw_cap_n = 1; fw_drv_n = 1;
    tick();

    // R2: transparent forward path
    fw_sel_n = 0; fw_cap_n = 0; fw_drv_n = 0; a_in = 8'h3C;
    tick();
    check("R2", "b_out transparent", b_out, 8'h3C);
    a_in = 8'hA5;
    tick();
    check("R2", "b_out follows", b_out, 8'hA5);

    // R3: capture gate high holds value
    fw_cap_n = 1; a_in = 8'h5A;
    tick();
    check("R3", "b_out held", b_out, 8'hA5);
    a_in = 8'hFF;
    tick();
    check("R3", "b_out held after input change", b_out, 8'hA5);

    // R9: single-cycle capture pulse
    fw_cap_n = 0; a_in = 8'h81;
    tick();
    fw_cap_n = 1; a_in = 8'h00;
    tick();
    check("R9", "b_out after one-cycle pulse", b_out, 8'h81);

    // R4: deselected path ignores capture gate
    fw_sel_n = 1; fw_cap_n = 0; a_in = 8'h77;
    tick();
    check("R5", "b_oe deselected", b_oe, 0);
    check("R6", "b_out idle zero", b_out, 0);
    a_in = 8'h66;
    tick();
    fw_sel_n = 0; fw_cap_n = 1; fw_drv_n = 0;
    tick();
    check("R4", "b_out kept while deselected", b_out, 8'h81);

    // R7, R8: both paths driving together
    rv_sel_n = 0; rv_cap_n = 0; rv_drv_n = 0; b_in = 8'hC3;
    tick();
    check("R7", "a_out return path", a_out, 8'hC3);
    check("R8", "contention both driving", contention, 1);
    check("R7", "b_out unaffected", b_out, 8'h81);
    rv_drv_n = 1;
    tick();
    check("R8", "contention cleared", contention, 0);
    check("R6", "a_out idle zero", a_out, 0);
    rv_drv_n = 0; rv_cap_n = 1; b_in = 8'h11;
    tick();
    check("R7", "a_out held value", a_out, 8'hC3);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      a_in     = 8'($urandom);
      b_in     = 8'($urandom);
      fw_sel_n = ($urandom % 4) == 0;
      fw_cap_n = ($urandom % 2) == 0;
      fw_drv_n = ($urandom % 4) == 0;
      rv_sel_n = ($urandom % 4) == 0;
      rv_cap_n = ($urandom % 2) == 0;
      rv_drv_n = ($urandom % 4) == 0;
      rst      = ($urandom % 200) == 0;
      tick();
    end
    rst = 0;
    summary();
  end

endmodule